// File: doc/BRIEF.md
# Base-Bounds Address Translator

This block turns a 32-bit virtual address into a physical address for one memory reference per cycle, without a page table or TLB. The low half of the address space is a user segment: every reference into it is checked against a bound register and, if it passes, relocated by adding a base register. Instruction fetches use one base/bound pair and loads and stores use a second, independent pair. This lets several user tasks share the same virtual addresses while each one lands in its own physical window.

The upper half of the address space belongs to the kernel and is reachable only in kernel mode. Two 512 MB kernel windows are mapped by dropping the top three address bits, one of them always uncached. The top 1 GB is passed through unchanged. Each reference also gets a cache-policy code taken from a table with one entry per 512 MB region. A reference that is out of bounds, or that comes from user mode into kernel space, is flagged as an address fault, and the faulting virtual address is latched for the exception handler.

The result appears one clock after the request. The base, bound and policy registers are loaded through a single write port.

Top module: `bbx_translator`

## Requirements
- R1: While `rst_n` is low and after its release, `rsp_valid` and `rsp_fault` are 0 and `bad_vaddr` is 0. All base, bound and policy registers reset to zero, so with no writes only user address 0 is in bounds.
- R2: A request presented with `req_valid`=1 produces its result on `rsp_*` at the next rising clock edge with `rsp_valid`=1. A cycle without a request gives `rsp_valid`=0, `rsp_fault`=0, `rsp_paddr`=0 and `rsp_attr`=0 at the next edge.
- R3: A fetch (`req_kind`=0) to an address below 0x80000000 is in bounds when the address is less than or equal to the instruction bound. It then yields `rsp_paddr` = address + instruction base, modulo 2^PA_W.
- R4: A load (`req_kind`=1), store (2) or reserved kind (3) to an address below 0x80000000 is checked and relocated the same way, using the data bound and data base.
- R5: A user-segment reference above its bound gives `rsp_fault`=1, `rsp_paddr`=0 and `rsp_attr`=0.
- R6: In kernel mode (`req_user`=0), an address in 0x80000000–0x9FFFFFFF yields the address with bits 31:29 cleared, with the policy of region 4.
- R7: In kernel mode, an address in 0xA0000000–0xBFFFFFFF yields the address with bits 31:29 cleared and always `rsp_attr`=0 (uncached), whatever the policy table holds.
- R8: In kernel mode, an address at or above 0xC0000000 is passed through unchanged with no bound check, with the policy of its region (6 or 7).
- R9: With `req_user`=1, any address with bit 31 set gives `rsp_fault`=1.
- R10: When `rsp_fault` is 1, `bad_vaddr` holds the virtual address of that faulting request in the same cycle. In every other cycle `bad_vaddr` keeps its value.
- R11: When `reg_we`=1, `reg_sel` chooses the target: 0 instruction base, 1 instruction bound, 2 data base, 3 data bound, 4 policy table. Values 5–7 change nothing. A write is seen by requests from the next cycle on; a request in the same cycle uses the old value.
- R12: The policy table holds 2 bits per region, region r at bits [2r+1:2r] of the written word. The region is address bits 31:29 of the virtual address. The codes are 0 uncached, 1 write-back, 2 write-through with allocate, and 3 write-through without allocate. An in-bounds user reference takes the policy of its own region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register write target |
| reg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved (as data) |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_attr | output | ATTR_W | Cache-policy code (0 on fault) |
| rsp_fault | output | 1 | Address fault |
| bad_vaddr | output | 32 | Last faulting virtual address |

## Verification
A register write and a translation that depends on that same register can fall in one cycle. The bench provokes this on purpose: it loads a data bound while a load just past the old bound is in flight, and it moves a base under a running fetch stream. Random stimulus also overlaps writes with requests. The behavioural model applies each write only after it has predicted that cycle's request, so the colliding request must show the old value and the next request the new one. Any ordering slip appears as a fault or address mismatch.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

   localparam int VA_W        = 32;
   localparam int REGION_N    = 8;
   localparam int REGION_BITS = 3;
   localparam int SEL_W       = 3;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEG_USER      = 2'd0,
      SEG_KCACHED   = 2'd1,
      SEG_KUNCACHED = 2'd2,
      SEG_KDIRECT   = 2'd3
   } seg_e;

   localparam logic [SEL_W-1:0] SEL_IBASE  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_IBOUND = 3'd1;
   localparam logic [SEL_W-1:0] SEL_DBASE  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_DBOUND = 3'd3;
   localparam logic [SEL_W-1:0] SEL_ATTR   = 3'd4;

   // Segment class from the three top address bits.
   function automatic seg_e seg_of(input logic [REGION_BITS-1:0] top);
      seg_e s;
      if (!top[2])            s = SEG_USER;
      else if (top == 3'b100) s = SEG_KCACHED;
      else if (top == 3'b101) s = SEG_KUNCACHED;
      else                    s = SEG_KDIRECT;
      return s;
   endfunction

endpackage

// File: rtl/bbx_regs.sv
module bbx_regs
   import bbx_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter int ATTR_W = 2
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [SEL_W-1:0]              sel,
   input  logic [VA_W-1:0]               wdata,
   output logic [PA_W-1:0]               ibase,
   output logic [VA_W-1:0]               ibound,
   output logic [PA_W-1:0]               dbase,
   output logic [VA_W-1:0]               dbound,
   output logic [REGION_N*ATTR_W-1:0]    attr_map
);

   localparam int MAP_W  = REGION_N * ATTR_W;
   localparam int PAIR_N = 2;

   logic [PA_W-1:0] base_q  [PAIR_N];
   logic [VA_W-1:0] bound_q [PAIR_N];

   // Pair 0 serves fetches, pair 1 serves data references.
   for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
      localparam logic [SEL_W-1:0] SEL_B = (p == 0) ? SEL_IBASE  : SEL_DBASE;
      localparam logic [SEL_W-1:0] SEL_L = (p == 0) ? SEL_IBOUND : SEL_DBOUND;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[p]  <= '0;
            bound_q[p] <= '0;
         end else if (we) begin
            if (sel == SEL_B) base_q[p]  <= wdata[PA_W-1:0];
            if (sel == SEL_L) bound_q[p] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       attr_map <= '0;
      else if (we && sel == SEL_ATTR)   attr_map <= wdata[MAP_W-1:0];
   end

   if (MAP_W < VA_W) begin : g_spare_map
      logic unused_map_bits;
      assign unused_map_bits = ^wdata[VA_W-1:MAP_W];
   end
   if (PA_W < VA_W) begin : g_spare_base
      logic unused_base_bits;
      assign unused_base_bits = ^wdata[VA_W-1:PA_W];
   end

   assign ibase  = base_q[0];
   assign ibound = bound_q[0];
   assign dbase  = base_q[1];
   assign dbound = bound_q[1];

   // R11: selector codes above the table select leave every register untouched
   assert_ignore_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel > SEL_ATTR) |=> ($stable(attr_map) && $stable(ibase) && $stable(ibound)
                                  && $stable(dbase) && $stable(dbound)));

endmodule

// File: rtl/bbx_seg_decode.sv
module bbx_seg_decode
   import bbx_pkg::*;
#(
   parameter int ATTR_W = 2
)(
   input  logic [VA_W-1:0]            vaddr,
   input  logic [REGION_N*ATTR_W-1:0] attr_map,
   output seg_e                       seg,
   output logic [ATTR_W-1:0]          region_attr
);

   logic [REGION_BITS-1:0] region;

   assign region = vaddr[VA_W-1 -: REGION_BITS];
   assign seg    = seg_of(region);

   always_comb begin
      region_attr = '0;
      for (int r = 0; r < REGION_N; r++) begin
         if (region == REGION_BITS'(r)) region_attr = attr_map[r*ATTR_W +: ATTR_W];
      end
   end

endmodule

// File: rtl/bbx_bound_check.sv
module bbx_bound_check
   import bbx_pkg::*;
#(
   parameter bit INCLUSIVE = 1'b1
)(
   input  logic [VA_W-1:0] vaddr,
   input  logic [VA_W-1:0] bound,
   output logic            in_bounds
);

   if (INCLUSIVE) begin : g_incl
      assign in_bounds = (vaddr <= bound);
   end else begin : g_excl
      assign in_bounds = (vaddr < bound);
   end

endmodule

// File: rtl/bbx_translator.sv
module bbx_translator
   import bbx_pkg::*;
#(
   parameter int PA_W            = 32,
   parameter int ATTR_W          = 2,
   parameter bit BOUND_INCLUSIVE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_sel,
   input  logic [31:0]        reg_wdata,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic               req_user,
   input  logic [31:0]        req_vaddr,
   output logic               rsp_valid,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [ATTR_W-1:0]  rsp_attr,
   output logic               rsp_fault,
   output logic [31:0]        bad_vaddr
);

   localparam int MAP_W   = REGION_N * ATTR_W;
   localparam int KOFF_W  = VA_W - REGION_BITS;

   if (PA_W < KOFF_W || PA_W > VA_W) begin : g_bad_pa
      $error("bbx_translator: PA_W must lie between %0d and %0d", KOFF_W, VA_W);
   end
   if (ATTR_W < 2 || MAP_W > VA_W) begin : g_bad_attr
      $error("bbx_translator: ATTR_W must fit the policy codes and the write port");
   end

   logic [PA_W-1:0]   ibase, dbase;
   logic [VA_W-1:0]   ibound, dbound;
   logic [MAP_W-1:0]  attr_map;

   bbx_regs #(.PA_W(PA_W), .ATTR_W(ATTR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .ibase    (ibase),
      .ibound   (ibound),
      .dbase    (dbase),
      .dbound   (dbound),
      .attr_map (attr_map)
   );

   seg_e              seg;
   logic [ATTR_W-1:0] region_attr;

   bbx_seg_decode #(.ATTR_W(ATTR_W)) u_seg (
      .vaddr       (req_vaddr),
      .attr_map    (attr_map),
      .seg         (seg),
      .region_attr (region_attr)
   );

   logic            is_fetch;
   logic [PA_W-1:0] use_base;
   logic [VA_W-1:0] use_bound;
   logic            in_bounds;

   assign is_fetch  = (acc_kind_e'(req_kind) == ACC_FETCH);
   assign use_base  = is_fetch ? ibase  : dbase;
   assign use_bound = is_fetch ? ibound : dbound;

   bbx_bound_check #(.INCLUSIVE(BOUND_INCLUSIVE)) u_bound (
      .vaddr     (req_vaddr),
      .bound     (use_bound),
      .in_bounds (in_bounds)
   );

   logic [VA_W-1:0]   va_cleared;
   logic [PA_W-1:0]   pa_reloc;
   logic [PA_W-1:0]   nx_paddr;
   logic [ATTR_W-1:0] nx_attr;
   logic              nx_fault;

   assign va_cleared = {{REGION_BITS{1'b0}}, req_vaddr[KOFF_W-1:0]};
   assign pa_reloc   = req_vaddr[PA_W-1:0] + use_base;

   always_comb begin
      nx_paddr = '0;
      nx_attr  = '0;
      nx_fault = 1'b0;
      unique case (seg)
         SEG_USER: begin
            nx_fault = !in_bounds;
            nx_paddr = pa_reloc;
            nx_attr  = region_attr;
         end
         SEG_KCACHED: begin
            nx_fault = req_user;
            nx_paddr = va_cleared[PA_W-1:0];
            nx_attr  = region_attr;
         end
         SEG_KUNCACHED: begin
            nx_fault = req_user;
            nx_paddr = va_cleared[PA_W-1:0];
            nx_attr  = '0;
         end
         default: begin
            nx_fault = req_user;
            nx_paddr = req_vaddr[PA_W-1:0];
            nx_attr  = region_attr;
         end
      endcase
      if (nx_fault || !req_valid) begin
         nx_paddr = '0;
         nx_attr  = '0;
      end
      if (!req_valid) nx_fault = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_attr  <= '0;
         rsp_fault <= 1'b0;
         bad_vaddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_paddr <= nx_paddr;
         rsp_attr  <= nx_attr;
         rsp_fault <= nx_fault;
         if (nx_fault) bad_vaddr <= req_vaddr;
      end
   end

   // R2: every request is answered on the following edge
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2: an empty response slot carries no fault and no address
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_attr == '0));

   // R9: user mode can never reach the upper half
   assert_user_kernel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && req_vaddr[VA_W-1]) |=> rsp_fault);

   // R7: the uncached kernel window ignores the policy table
   assert_kseg_uncached_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_user && req_vaddr[VA_W-1 -: REGION_BITS] == 3'b101)
         |=> (!rsp_fault && rsp_attr == '0));

   // R10: the latched address belongs to the fault being shown
   assert_bad_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (bad_vaddr == $past(req_vaddr)));

   // R10: without a fault the latched address holds
   assert_bad_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault |-> $stable(bad_vaddr));

endmodule

// File: tb/tb_bbx_translator.sv
`timescale 1ns/1ps
module tb_bbx_translator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_attr;
   logic        rsp_fault;
   logic [31:0] bad_vaddr;

   always #5 clk = ~clk;

   bbx_translator dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_user(req_user), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
      .rsp_fault(rsp_fault), .bad_vaddr(bad_vaddr)
   );

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   // behavioural model state
   logic [31:0] m_ibase = '0, m_ibound = '0, m_dbase = '0, m_dbound = '0;
   logic [15:0] m_attr = '0;
   logic [31:0] m_bad = '0;

   // expected response for the request driven last cycle
   logic        e_valid = 1'b0;
   logic [31:0] e_paddr = '0;
   logic [1:0]  e_attr = '0;
   logic        e_fault = 1'b0;
   string       e_tag = "R2";

   task automatic predict(input logic v, input logic [1:0] k, input logic u,
                          input logic [31:0] a, input logic wrote);
      logic [31:0] base, bound;
      e_valid = v; e_paddr = '0; e_attr = '0; e_fault = 1'b0; e_tag = "R2";
      if (v) begin
         base  = (k == 2'd0) ? m_ibase  : m_dbase;
         bound = (k == 2'd0) ? m_ibound : m_dbound;
         if (a < 32'h8000_0000) begin
            if (a <= bound) begin
               e_paddr = a + base;
               e_attr  = m_attr[{a[31:29], 1'b0} +: 2];
               e_tag   = (k == 2'd0) ? "R3/R12" : "R4/R12";
            end else begin
               e_fault = 1'b1; e_tag = "R5";
            end
         end else if (u) begin
            e_fault = 1'b1; e_tag = "R9";
         end else if (a < 32'hA000_0000) begin
            e_paddr = a & 32'h1FFF_FFFF; e_attr = m_attr[9:8]; e_tag = "R6";
         end else if (a < 32'hC000_0000) begin
            e_paddr = a & 32'h1FFF_FFFF; e_attr = 2'd0; e_tag = "R7";
         end else begin
            e_paddr = a; e_attr = m_attr[{a[31:29], 1'b0} +: 2]; e_tag = "R8";
         end
         if (e_fault) m_bad = a;
      end
      if (wrote) e_tag = {e_tag, "/R11"};
   endtask

   task automatic compare();
      compared++;
      if (rsp_valid !== e_valid || rsp_paddr !== e_paddr || rsp_attr !== e_attr ||
          rsp_fault !== e_fault || bad_vaddr !== m_bad) begin
         mismatched++;
         $display("FAIL %s/R10 t=%0t: got v=%0b pa=%h at=%0d f=%0b bad=%h exp v=%0b pa=%h at=%0d f=%0b bad=%h",
                  e_tag, $time, rsp_valid, rsp_paddr, rsp_attr, rsp_fault, bad_vaddr,
                  e_valid, e_paddr, e_attr, e_fault, m_bad);
      end
   endtask

   // One clock: check last cycle's result, then drive and predict the next.
   task automatic tick(input logic v, input logic [1:0] k, input logic u, input logic [31:0] a,
                       input logic we, input logic [2:0] sel, input logic [31:0] wd);
      @(negedge clk);
      compare();
      predict(v, k, u, a, we);
      if (we) begin
         case (sel)
            3'd0: m_ibase  = wd;
            3'd1: m_ibound = wd;
            3'd2: m_dbase  = wd;
            3'd3: m_dbound = wd;
            3'd4: m_attr   = wd[15:0];
            default: ;
         endcase
      end
      req_valid = v; req_kind = k; req_user = u; req_vaddr = a;
      reg_we = we; reg_sel = sel; reg_wdata = wd;
   endtask

   task automatic req(input logic [1:0] k, input logic u, input logic [31:0] a);
      tick(1'b1, k, u, a, 1'b0, 3'd0, 32'd0);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
      tick(1'b0, 2'd0, 1'b0, 32'd0, 1'b1, sel, wd);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      mismatched++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      compared++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || bad_vaddr !== 32'd0) begin
         mismatched++;
         $display("FAIL R1: got v=%0b f=%0b bad=%h exp 0 0 0", rsp_valid, rsp_fault, bad_vaddr);
      end
      rst_n = 1'b1;

      // R1: zero bounds after reset: only address 0 in bounds
      req(2'd0, 1'b1, 32'h0000_0000);
      req(2'd1, 1'b1, 32'h0000_0004);
      tick(1'b0, 2'd0, 1'b0, 32'd0, 1'b0, 3'd0, 32'd0);

      // R11: load all registers
      wr(3'd0, 32'h1000_0000);
      wr(3'd1, 32'h0000_FFFF);
      wr(3'd2, 32'h2000_0000);
      wr(3'd3, 32'h0000_0FFF);
      // R12: region0=1 region1=2 region4=2 region5=3 region6=3 region7=1
      wr(3'd4, 32'h0000_7E09);

      // R3 / R4 / R5: bound edges
      req(2'd0, 1'b1, 32'h0000_FFFF);
      req(2'd0, 1'b1, 32'h0001_0000);
      req(2'd1, 1'b1, 32'h0000_0FFF);
      req(2'd1, 1'b1, 32'h0000_1000);
      req(2'd2, 1'b0, 32'h0000_1000);
      req(2'd3, 1'b1, 32'h0000_0800);
      req(2'd0, 1'b0, 32'h0000_1000);
      // R6 / R7 / R8: kernel windows
      req(2'd1, 1'b0, 32'h8000_1234);
      req(2'd1, 1'b0, 32'hA000_0010);
      req(2'd0, 1'b0, 32'hC000_0040);
      req(2'd2, 1'b0, 32'hFFFF_FFFC);
      // R9: user into kernel space
      req(2'd0, 1'b1, 32'h8000_0000);
      req(2'd1, 1'b1, 32'hC000_0000);
      req(2'd1, 1'b1, 32'hBFFF_FFFF);
      // R11: write and dependent load in the same cycle see the old bound
      tick(1'b1, 2'd1, 1'b1, 32'h0000_2000, 1'b1, 3'd3, 32'h0000_FFFF);
      req(2'd1, 1'b1, 32'h0000_2000);
      // R11: codes 5..7 are ignored
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd7, 32'h0000_0000);
      req(2'd1, 1'b1, 32'h0000_2000);
      req(2'd1, 1'b0, 32'h8000_0000);
      // R3: base wraps modulo 2^32; base change under a fetch stream
      wr(3'd2, 32'hFFFF_F000);
      req(2'd1, 1'b1, 32'h0000_1800);
      wr(3'd1, 32'h7FFF_FFFF);
      req(2'd0, 1'b1, 32'h2000_0000);
      tick(1'b1, 2'd0, 1'b1, 32'h2000_0004, 1'b1, 3'd0, 32'h0000_0100);
      req(2'd0, 1'b1, 32'h2000_0008);
      req(2'd0, 1'b1, 32'h7FFF_FFFF);

      // random phase with overlapping writes
      for (int i = 0; i < 4000; i++) begin
         logic [1:0]  k;
         logic        u, v, we;
         logic [2:0]  sel;
         logic [31:0] a, wd, bnd;
         int          cat;
         k   = 2'($urandom_range(0, 3));
         u   = 1'($urandom_range(0, 1));
         v   = ($urandom_range(0, 9) != 0);
         cat = $urandom_range(0, 9);
         bnd = (k == 2'd0) ? m_ibound : m_dbound;
         case (cat)
            0, 1, 2: a = bnd + 32'($urandom_range(0, 4)) - 32'd2;
            3, 4:    a = {1'b0, 31'($urandom)};
            5:       a = {3'b100, 29'($urandom)};
            6:       a = {3'b101, 29'($urandom)};
            7:       a = {2'b11, 30'($urandom)};
            default: a = $urandom;
         endcase
         we  = ($urandom_range(0, 4) == 0);
         sel = 3'($urandom_range(0, 7));
         wd  = $urandom;
         if ((sel == 3'd1 || sel == 3'd3) && $urandom_range(0, 1) == 1) wd = {1'b0, 31'(wd >> 8)};
         tick(v, k, u, a, we, sel, wd);
      end
      tick(1'b0, 2'd0, 1'b0, 32'd0, 1'b0, 3'd0, 32'd0);
      tick(1'b0, 2'd0, 1'b0, 32'd0, 1'b0, 3'd0, 32'd0);
      finish_run();
   end

endmodule